// File: doc/BRIEF.md
# Masked Multi-Plane Blit Engine

This engine copies a multi-plane image onto an interleaved bitplane background with a cookie-cut merge. Wherever a mask bit is one, the output bit comes from the source image. Wherever it is zero, the background bit already in the destination is kept. In an interleaved layout, the rows of all planes that belong to one image line are stored next to each other. One start operation covers every plane of every row.

The mask holds a single line per image row. For each column, the engine reads the mask word once and holds it. It then applies that word to every plane at that column, so a plane word costs three memory cycles instead of four. A mode input can replace fetched mask words with a constant mask captured at start, and then no mask reads occur at all. The engine reaches memory through a one-word request/grant port. It reports activity with a busy level and a one-cycle done pulse.

Top module: `mplane_cookie_blit`

## Requirements
- R1: A start pulse seen while idle raises `busy` on the next clock edge. All configuration inputs are captured at that edge, so later changes to them have no effect on the operation.
- R2: Every destination word written equals (mask & source) | (~mask & background), where background is the word read from that destination address in the same plane step.
- R3: Accesses follow a fixed order. Rows run from first to last, columns from left to right within a row, and planes in order within a column. In mask-cache mode, each column begins with one mask read at `msk_base + r*(W+msk_mod) + c`. Each plane p then has a source read at `src_base + (r*P+p)*(W+src_mod) + c`, a background read at `dst_base + (r*P+p)*(W+dst_mod) + c`, and a write to that same destination address.
- R4: In mask-cache mode (`fixed_mode`=0), a blit makes exactly W*H mask reads and W*H*(1+3P) granted accesses in total.
- R5: In fixed-mask mode (`fixed_mode`=1), no mask reads occur, the total is W*H*3P accesses, and the captured `fixed_mask` word is used as the mask for every destination word.
- R6: While `mem_req` is high and `mem_gnt` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values. The result is the same as with grant held high.
- R7: `busy` falls on the edge one cycle after the edge that grants the final destination write. `done` is high for exactly the one cycle in which `busy` first reads low.
- R8: A start pulse received while `busy` is high is ignored, and the running blit finishes with the same accesses and data as if no such pulse had arrived.
- R9: A start with width, height or plane count equal to zero makes no memory access. It keeps `busy` high for one cycle and then pulses `done`.
- R10: A plane count above 6 (values 7 and up in the 3-bit field) is treated as 6.
- R11: During and right after reset, `busy`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only while idle |
| fixed_mode | input | 1 | 1 selects the constant mask, 0 selects the fetched and cached mask |
| width_words | input | WIDTH_W | Image width W in words |
| height_rows | input | HEIGHT_W | Image height H in rows |
| plane_cnt | input | 3 | Plane count P (1 to 6) |
| src_base | input | ADDR_W | Source start word address |
| msk_base | input | ADDR_W | Mask start word address |
| dst_base | input | ADDR_W | Destination start word address |
| src_mod | input | ADDR_W | Words skipped after each source plane line |
| msk_mod | input | ADDR_W | Words skipped after each mask line |
| dst_mod | input | ADDR_W | Words skipped after each destination plane line |
| fixed_mask | input | DATA_W | Constant mask word for fixed mode |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_gnt | input | 1 | Grant; one word moves per granted cycle |
| mem_rdata | input | DATA_W | Read data, valid in the granted cycle |
| busy | output | 1 | Blit in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the address walk across modulo gaps with different modulos for source, mask and destination. A design that advanced the mask by the source stride, or fetched the mask once per plane, would write into the gap words or show too many mask reads. Random grant gaps test whether the held request changes while stalled, which would corrupt or skip words. The bench also covers a start pulse during a blit, zero-sized starts and a plane count of 7. A design that wrongly handled these would restart partway, hang busy, touch memory, or stop after an odd number of planes.

// File: rtl/mpb_pkg.sv
package mpb_pkg;

    localparam int unsigned MPB_PLANE_W   = 3;
    localparam int unsigned MPB_MAX_PLANE = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MASK,
        ST_SRC,
        ST_BG,
        ST_WR,
        ST_FIN
    } mpb_state_e;

    // Plane counts above the supported maximum are clipped to it.
    function automatic logic [MPB_PLANE_W-1:0] clamp_planes(input logic [MPB_PLANE_W-1:0] p);
        if (p > MPB_PLANE_W'(MPB_MAX_PLANE))
            return MPB_PLANE_W'(MPB_MAX_PLANE);
        return p;
    endfunction

endpackage

// File: rtl/mpb_merge.sv
module mpb_merge #(
    parameter int unsigned DW = 16
) (
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] bg,
    output logic [DW-1:0] result
);
    always_comb begin
        result = (mask & src) | (~mask & bg);
    end
endmodule

// File: rtl/mpb_seq.sv
module mpb_seq
    import mpb_pkg::*;
#(
    parameter int unsigned WW = 8,
    parameter int unsigned HW = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [WW-1:0]          cfg_w,
    input  logic [HW-1:0]          cfg_h,
    input  logic [MPB_PLANE_W-1:0] cfg_p,
    input  logic                   cfg_fixed,
    input  logic                   gnt,
    output mpb_state_e             state,
    output logic                   busy,
    output logic                   done,
    output logic                   fixed_q,
    output logic                   load,
    output logic                   ev_plane,
    output logic                   ev_col,
    output logic                   ev_row
);
    logic [WW-1:0]          w_q, col_q;
    logic [HW-1:0]          h_q, row_q;
    logic [MPB_PLANE_W-1:0] p_q, pl_q;
    logic                   last_p, last_c, last_r, wr_go;
    mpb_state_e             col_entry;

    always_comb begin
        last_p    = (pl_q == p_q - MPB_PLANE_W'(1));
        last_c    = (col_q == w_q - WW'(1));
        last_r    = (row_q == h_q - HW'(1));
        wr_go     = (state == ST_WR) && gnt;
        load      = (state == ST_IDLE) && start;
        ev_plane  = wr_go && !last_p;
        ev_col    = wr_go && last_p && !last_c;
        ev_row    = wr_go && last_p && last_c && !last_r;
        busy      = (state != ST_IDLE);
        col_entry = fixed_q ? ST_SRC : ST_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            done    <= 1'b0;
            fixed_q <= 1'b0;
            w_q     <= '0;
            h_q     <= '0;
            p_q     <= '0;
            col_q   <= '0;
            row_q   <= '0;
            pl_q    <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        w_q     <= cfg_w;
                        h_q     <= cfg_h;
                        p_q     <= cfg_p;
                        fixed_q <= cfg_fixed;
                        col_q   <= '0;
                        row_q   <= '0;
                        pl_q    <= '0;
                        if (cfg_w == '0 || cfg_h == '0 || cfg_p == '0)
                            state <= ST_FIN;
                        else
                            state <= cfg_fixed ? ST_SRC : ST_MASK;
                    end
                end
                ST_MASK: if (gnt) state <= ST_SRC;
                ST_SRC:  if (gnt) state <= ST_BG;
                ST_BG:   if (gnt) state <= ST_WR;
                ST_WR: begin
                    if (gnt) begin
                        if (!last_p) begin
                            pl_q  <= pl_q + MPB_PLANE_W'(1);
                            state <= ST_SRC;
                        end else begin
                            pl_q <= '0;
                            if (!last_c) begin
                                col_q <= col_q + WW'(1);
                                state <= col_entry;
                            end else begin
                                col_q <= '0;
                                if (!last_r) begin
                                    row_q <= row_q + HW'(1);
                                    state <= col_entry;
                                end else begin
                                    state <= ST_FIN;
                                end
                            end
                        end
                    end
                end
                ST_FIN: begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mpb_ptr.sv
module mpb_ptr
    import mpb_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned WW = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [AW-1:0]          src_base,
    input  logic [AW-1:0]          msk_base,
    input  logic [AW-1:0]          dst_base,
    input  logic [AW-1:0]          src_mod,
    input  logic [AW-1:0]          msk_mod,
    input  logic [AW-1:0]          dst_mod,
    input  logic [WW-1:0]          cfg_w,
    input  logic [MPB_PLANE_W-1:0] cfg_p,
    input  logic                   ev_plane,
    input  logic                   ev_col,
    input  logic                   ev_row,
    input  mpb_state_e             state,
    output logic [AW-1:0]          addr
);
    // Strides between plane lines, spans between image rows.
    logic [AW-1:0] s_str, d_str, m_str, s_span, d_span;
    logic [AW-1:0] s_row, d_row, m_row;
    logic [AW-1:0] s_col, d_col;
    logic [AW-1:0] s_cur, d_cur, m_cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_str <= '0; d_str <= '0; m_str <= '0;
            s_span <= '0; d_span <= '0;
            s_row <= '0; d_row <= '0; m_row <= '0;
            s_col <= '0; d_col <= '0;
            s_cur <= '0; d_cur <= '0; m_cur <= '0;
        end else if (load) begin
            s_str  <= AW'(cfg_w) + src_mod;
            d_str  <= AW'(cfg_w) + dst_mod;
            m_str  <= AW'(cfg_w) + msk_mod;
            s_span <= AW'(cfg_p) * (AW'(cfg_w) + src_mod);
            d_span <= AW'(cfg_p) * (AW'(cfg_w) + dst_mod);
            s_row  <= src_base; s_col <= src_base; s_cur <= src_base;
            d_row  <= dst_base; d_col <= dst_base; d_cur <= dst_base;
            m_row  <= msk_base; m_cur <= msk_base;
        end else if (ev_plane) begin
            s_cur <= s_cur + s_str;
            d_cur <= d_cur + d_str;
        end else if (ev_col) begin
            s_col <= s_col + AW'(1);
            s_cur <= s_col + AW'(1);
            d_col <= d_col + AW'(1);
            d_cur <= d_col + AW'(1);
            m_cur <= m_cur + AW'(1);
        end else if (ev_row) begin
            s_row <= s_row + s_span;
            s_col <= s_row + s_span;
            s_cur <= s_row + s_span;
            d_row <= d_row + d_span;
            d_col <= d_row + d_span;
            d_cur <= d_row + d_span;
            m_row <= m_row + m_str;
            m_cur <= m_row + m_str;
        end
    end

    always_comb begin
        case (state)
            ST_MASK:      addr = m_cur;
            ST_SRC:       addr = s_cur;
            ST_BG, ST_WR: addr = d_cur;
            default:      addr = '0;
        endcase
    end
endmodule

// File: rtl/mplane_cookie_blit.sv
module mplane_cookie_blit
    import mpb_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned WIDTH_W  = 8,
    parameter int unsigned HEIGHT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   fixed_mode,
    input  logic [WIDTH_W-1:0]     width_words,
    input  logic [HEIGHT_W-1:0]    height_rows,
    input  logic [MPB_PLANE_W-1:0] plane_cnt,
    input  logic [ADDR_W-1:0]      src_base,
    input  logic [ADDR_W-1:0]      msk_base,
    input  logic [ADDR_W-1:0]      dst_base,
    input  logic [ADDR_W-1:0]      src_mod,
    input  logic [ADDR_W-1:0]      msk_mod,
    input  logic [ADDR_W-1:0]      dst_mod,
    input  logic [DATA_W-1:0]      fixed_mask,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [DATA_W-1:0]      mem_wdata,
    input  logic                   mem_gnt,
    input  logic [DATA_W-1:0]      mem_rdata,
    output logic                   busy,
    output logic                   done
);
    mpb_state_e             state;
    logic                   fixed_q, load, ev_plane, ev_col, ev_row;
    logic [MPB_PLANE_W-1:0] planes_eff;
    logic [DATA_W-1:0]      fmask_q, mask_q, src_q, bg_q, mask_use;

    always_comb planes_eff = clamp_planes(plane_cnt);

    mpb_seq #(.WW(WIDTH_W), .HW(HEIGHT_W)) seq_i (
        .clk(clk), .rst(rst), .start(start),
        .cfg_w(width_words), .cfg_h(height_rows), .cfg_p(planes_eff),
        .cfg_fixed(fixed_mode), .gnt(mem_gnt),
        .state(state), .busy(busy), .done(done), .fixed_q(fixed_q),
        .load(load), .ev_plane(ev_plane), .ev_col(ev_col), .ev_row(ev_row)
    );

    mpb_ptr #(.AW(ADDR_W), .WW(WIDTH_W)) ptr_i (
        .clk(clk), .rst(rst), .load(load),
        .src_base(src_base), .msk_base(msk_base), .dst_base(dst_base),
        .src_mod(src_mod), .msk_mod(msk_mod), .dst_mod(dst_mod),
        .cfg_w(width_words), .cfg_p(planes_eff),
        .ev_plane(ev_plane), .ev_col(ev_col), .ev_row(ev_row),
        .state(state), .addr(mem_addr)
    );

    // Held data words: mask cached per column, source and background per plane.
    always_ff @(posedge clk) begin
        if (rst) begin
            fmask_q <= '0;
            mask_q  <= '0;
            src_q   <= '0;
            bg_q    <= '0;
        end else begin
            if (load)                         fmask_q <= fixed_mask;
            if (state == ST_MASK && mem_gnt)  mask_q  <= mem_rdata;
            if (state == ST_SRC  && mem_gnt)  src_q   <= mem_rdata;
            if (state == ST_BG   && mem_gnt)  bg_q    <= mem_rdata;
        end
    end

    always_comb begin
        mask_use = fixed_q ? fmask_q : mask_q;
        mem_req  = (state == ST_MASK) || (state == ST_SRC) ||
                   (state == ST_BG)   || (state == ST_WR);
        mem_we   = (state == ST_WR);
    end

    mpb_merge #(.DW(DATA_W)) merge_i (
        .mask(mask_use), .src(src_q), .bg(bg_q), .result(mem_wdata)
    );
endmodule

// File: rtl/mpb_checker.sv
module mpb_checker #(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          mem_req,
    input logic          mem_gnt,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata
);
    p_start_busy_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    p_write_is_req_r2: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) &&
                                   $stable(mem_addr) && $stable(mem_wdata)));

    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    p_fall_gives_done_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_req_needs_busy_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);
endmodule

bind mplane_cookie_blit mpb_checker #(.AW(ADDR_W), .DW(DATA_W)) chk_i (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/mplane_cookie_blit_tb.sv
`timescale 1ns/1ps
module mplane_cookie_blit_tb_top;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int SB = 0;
    localparam int MB = 256;
    localparam int DB = 512;
    localparam logic [15:0] FMASK = 16'h0FF0;

    typedef struct packed {
        int w; int h; int p; bit fx; int sm; int mm; int dm; bit rnd;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1, 1, 1, 1'b0, 0, 0, 0, 1'b0},
        '{3, 2, 4, 1'b0, 1, 2, 1, 1'b0},
        '{2, 3, 6, 1'b0, 0, 1, 2, 1'b1},
        '{4, 2, 3, 1'b1, 2, 0, 0, 1'b1},
        '{2, 2, 7, 1'b0, 1, 0, 1, 1'b0},
        '{3, 3, 2, 1'b1, 0, 3, 2, 1'b0},
        '{4, 4, 6, 1'b0, 2, 2, 2, 1'b1}
    };

    logic clk = 1'b0;
    logic rst, start, fixed_mode, mem_req, mem_we, mem_gnt, busy, done;
    logic [7:0]  width_words, height_rows;
    logic [2:0]  plane_cnt;
    logic [AW-1:0] src_base, msk_base, dst_base, src_mod, msk_mod, dst_mod, mem_addr;
    logic [DW-1:0] fixed_mask, mem_wdata, mem_rdata;

    always #5 clk = ~clk;

    mplane_cookie_blit dut_i (
        .clk(clk), .rst(rst), .start(start), .fixed_mode(fixed_mode),
        .width_words(width_words), .height_rows(height_rows), .plane_cnt(plane_cnt),
        .src_base(src_base), .msk_base(msk_base), .dst_base(dst_base),
        .src_mod(src_mod), .msk_mod(msk_mod), .dst_mod(dst_mod),
        .fixed_mask(fixed_mask), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .busy(busy), .done(done)
    );

    function automatic logic [15:0] pat(int i, int s);
        return 16'((i * 40503) ^ (s * 977) ^ (i << 7));
    endfunction

    // Memory model, one port, combinational read in the granted cycle.
    logic [15:0] mem [0:1023];
    logic [15:0] emem [0:1023];
    logic init_go = 1'b0;
    int   init_seed = 0;
    assign mem_rdata = mem[mem_addr[9:0]];

    always @(posedge clk) begin
        if (init_go) begin
            for (int i = 0; i < 1024; i++) mem[i] <= pat(i, init_seed);
        end else if (mem_req && mem_gnt && mem_we) begin
            mem[mem_addr[9:0]] <= mem_wdata;
        end
    end

    // Grant driver.
    logic rnd_mode = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    always @(negedge clk) begin
        lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_gnt <= rnd_mode ? lfsr[0] : 1'b1;
    end

    // Access monitor with an independent model of the expected order.
    logic mon_clr = 1'b0;
    int cur_w, cur_h, cur_p, cur_sm, cur_mm, cur_dm;
    bit cur_fx;
    int acc_cnt, mask_cnt, order_err, stall_cnt, last_wr, cyc;
    int mr, mc, mp, mph;
    always @(posedge clk) begin
        int ea;
        bit ew;
        if (mon_clr) begin
            acc_cnt = 0; mask_cnt = 0; order_err = 0; stall_cnt = 0;
            mr = 0; mc = 0; mp = 0; mph = cur_fx ? 1 : 0;
        end else if (mem_req && mem_gnt) begin
            acc_cnt++;
            if (!mem_we && mem_addr >= AW'(MB) && mem_addr < AW'(DB)) mask_cnt++;
            case (mph)
                0:       begin ea = MB + mr * (cur_w + cur_mm) + mc; ew = 1'b0; end
                1:       begin ea = SB + (mr * cur_p + mp) * (cur_w + cur_sm) + mc; ew = 1'b0; end
                2:       begin ea = DB + (mr * cur_p + mp) * (cur_w + cur_dm) + mc; ew = 1'b0; end
                default: begin ea = DB + (mr * cur_p + mp) * (cur_w + cur_dm) + mc; ew = 1'b1; end
            endcase
            if (mem_addr != AW'(ea) || mem_we != ew) order_err++;
            if (mem_we) last_wr = cyc;
            if (mph < 3) mph++;
            else begin
                mph = 1; mp++;
                if (mp == cur_p) begin
                    mp = 0; mc++; mph = cur_fx ? 1 : 0;
                    if (mc == cur_w) begin mc = 0; mr++; end
                end
            end
        end
        if (!mon_clr && mem_req && !mem_gnt) stall_cnt++;
        cyc++;
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input int w, input int h, input int p, input bit fx,
                           input int sm, input int mm, input int dm);
        width_words = 8'(w); height_rows = 8'(h); plane_cnt = 3'(p);
        fixed_mode = fx; fixed_mask = FMASK;
        src_base = AW'(SB); msk_base = AW'(MB); dst_base = AW'(DB);
        src_mod = AW'(sm); msk_mod = AW'(mm); dst_mod = AW'(dm);
    endtask

    task automatic scramble_cfg();
        width_words = 8'd1; height_rows = 8'd9; plane_cnt = 3'd1;
        fixed_mode = ~fixed_mode; fixed_mask = 16'h0000;
        src_base = 16'h0300; msk_base = 16'h0301; dst_base = 16'h0302;
        src_mod = 16'd5; msk_mod = 16'd5; dst_mod = 16'd5;
    endtask

    task automatic run_vec(input int idx);
        vec_t v;
        int ep, nw, mis, first_a, n;
        string tag;
        v  = VECS[idx];
        ep = (v.p > 6) ? 6 : v.p;
        tag = (idx == 4) ? "R10" : (v.fx ? "R5" : "R2");
        cur_w = v.w; cur_h = v.h; cur_p = ep; cur_fx = v.fx;
        cur_sm = v.sm; cur_mm = v.mm; cur_dm = v.dm;
        rnd_mode = v.rnd;
        @(negedge clk); init_seed = idx * 7 + 3; init_go = 1'b1;
        @(negedge clk); init_go = 1'b0; mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
        for (int i = 0; i < 1024; i++) emem[i] = pat(i, init_seed);
        for (int r = 0; r < v.h; r++)
            for (int c = 0; c < v.w; c++)
                for (int p = 0; p < ep; p++) begin
                    logic [15:0] m, s;
                    int da;
                    m  = v.fx ? FMASK : pat(MB + r * (v.w + v.mm) + c, init_seed);
                    s  = pat(SB + (r * ep + p) * (v.w + v.sm) + c, init_seed);
                    da = DB + (r * ep + p) * (v.w + v.dm) + c;
                    emem[da] = (m & s) | (~m & emem[da]);
                end
        set_cfg(v.w, v.h, v.p, v.fx, v.sm, v.mm, v.dm);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R1 busy after start", busy, 1);
        scramble_cfg();
        if (idx == 1) begin
            // R8: start pulses mid-blit with a different configuration.
            repeat (4) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
            repeat (9) @(negedge clk);
            start = 1'b1; @(negedge clk); @(negedge clk); start = 1'b0;
        end
        n = 0;
        while (busy && n < 5000) begin @(negedge clk); n++; end
        chk(n < 5000, "R7 watchdog busy never fell", n, 5000);
        chk(cyc - last_wr == 2, "R7 busy fall after last write", cyc - last_wr, 2);
        chk(done == 1'b1, "R7 done with busy fall", done, 1);
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", done, 0);
        mis = 0; first_a = 0;
        for (int i = 0; i < 1024; i++)
            if (mem[i] !== emem[i]) begin
                if (mis == 0) first_a = i;
                mis++;
            end
        chk(mis == 0, {tag, " destination image"}, mem[first_a], emem[first_a]);
        chk(order_err == 0, "R3 access order/addresses", order_err, 0);
        nw = v.w * v.h * (v.fx ? 3 * ep : 1 + 3 * ep);
        chk(acc_cnt == nw, v.fx ? "R5 access count" : "R4 access count", acc_cnt, nw);
        chk(mask_cnt == (v.fx ? 0 : v.w * v.h), v.fx ? "R5 mask reads" : "R4 mask reads",
            mask_cnt, v.fx ? 0 : v.w * v.h);
        if (idx == 1)
            chk(mis == 0 && acc_cnt == nw, "R8 start while busy ignored", acc_cnt, nw);
        if (v.rnd)
            chk(stall_cnt > 0 && mis == 0, "R6 stalled run result", stall_cnt, 1);
    endtask

    task automatic run_zero(input int w, input int h, input int p);
        cur_fx = 1'b0; rnd_mode = 1'b0;
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
        set_cfg(w, h, p, 1'b0, 0, 0, 0);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R9 zero-size busy one cycle", busy, 1);
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b1, "R9 zero-size done", {busy, done}, 1);
        repeat (3) @(negedge clk);
        chk(acc_cnt == 0, "R9 zero-size no access", acc_cnt, 0);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0;
        set_cfg(0, 0, 0, 1'b0, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R11 busy in reset", busy, 0);
        chk(done == 1'b0, "R11 done in reset", done, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0,
            "R11 idle after reset", {busy, done, mem_req}, 0);
        for (int k = 0; k < NV; k++) run_vec(k);
        run_zero(0, 2, 3);
        run_zero(2, 0, 3);
        run_zero(2, 2, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule